// File: doc/BRIEF.md
# Indexed MAC Address Match Table

This block holds eight destination-address entries for an Ethernet receive path and compares an incoming 48-bit destination address against all of them in parallel. The entries share one 40-bit upper prefix and differ only in their lowest byte. Each entry also carries a valid flag, an accept-or-filter flag and a receive channel number.

Software programs the table through three word registers. It first selects an entry through the selector register. It then writes the prefix register, which holds address bytes 5 to 2; this is needed only once for all entries. A write to the entry register commits the selected entry. That write also replaces the shared byte 1. Entries that are not used are committed with the valid flag cleared.

The receive side raises a strobe together with the address. One cycle later the block reports a hit, the winning entry's channel and its accept flag. When more than one entry matches, the lowest-numbered entry wins.

Top module: `mac_match_table`

## Requirements
- R1: A write to offset 0 stores bits [2:0] of the write data as the entry selector. A read of offset 0 returns the selector in bits [2:0] and zero in all bits above.
- R2: A write to offset 1 stores the full 32-bit word as address bytes 5..2, with byte 5 in bits [31:24]. A read of offset 1 returns the stored word.
- R3: A write to offset 2 commits the selected entry from one word. The fields are byte 0 in [7:0], byte 1 in [15:8], channel in [18:16], accept in [19] and valid in [20]. A read of offset 2 returns these fields for the currently selected entry, with zero in bits [31:21]. The other entries are not changed.
- R4: Byte 1 is shared by all entries. An entry-register write for any index changes byte 1 for every entry, both in readback and in matching.
- R5: A strobed address da[47:0] matches entry i when all three of these hold: da[47:16] equals the stored bytes 5..2, da[15:8] equals the shared byte 1, and da[7:0] equals entry i's byte 0. On the cycle after the strobe, hit is 1, and chan and accept show that entry's channel and flag.
- R6: An entry whose valid flag is 0 never produces a hit, even when its address matches.
- R7: When several valid entries match, the lowest-numbered entry is reported.
- R8: When there is no match, hit, chan and accept are all 0. On the cycle after a cycle without a strobe, they are also all 0.
- R9: Reset clears the selector, the prefix, byte 1 and every valid flag. During reset, hit, chan and accept are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Word offset: 0 selector, 1 prefix, 2 entry |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| da_valid | input | 1 | Destination-address strobe |
| da | input | 48 | Destination address |
| hit | output | 1 | A valid entry matched (one cycle after the strobe) |
| chan | output | 3 | Channel of the winning entry |
| accept | output | 1 | 1 means accept, 0 means filter |

## Verification
The table is loaded with the following entries:
- an accept entry on channel 0;
- a filter entry on channel 5;
- an invalid entry whose byte 0 is unique;
- a second valid entry with the same byte 0 as the channel-5 entry;
- a valid entry at the highest index.

Lookups cover exact hits, the duplicated byte 0 (which separates the lowest-index rule from the other orders), and the invalid entry's address (which shows whether the valid flag is honoured). Further lookups change only byte 5, only byte 2 or only byte 1. Each of these must miss, which shows that every part of the prefix is compared. A late rewrite of byte 1 through the highest entry then shows that the shared byte moves for entry 0 as well.

// File: rtl/mac_match_table.sv
module mac_match_table #(
  parameter int N_ENTRY = 8,
  parameter int CHAN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              da_valid,
  input  logic [47:0]       da,
  output logic              hit,
  output logic [CHAN_W-1:0] chan,
  output logic              accept
);
  localparam int IDX_W   = $clog2(N_ENTRY);
  localparam int CH_LSB  = 16;
  localparam int ACC_BIT = CH_LSB + CHAN_W;
  localparam int VLD_BIT = ACC_BIT + 1;
  localparam int LO_W    = VLD_BIT + 1;

  logic [IDX_W-1:0]  sel_q;
  logic [31:0]       hi_q;
  logic [7:0]        b1_q;
  logic [N_ENTRY-1:0] vld_q, acc_q;
  logic [7:0]        b0_q [N_ENTRY];
  logic [CHAN_W-1:0] ch_q [N_ENTRY];

  wire wr_sel = reg_wr && reg_addr == 2'd0;
  wire wr_hi  = reg_wr && reg_addr == 2'd1;
  wire wr_lo  = reg_wr && reg_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      hi_q  <= '0;
      b1_q  <= '0;
      vld_q <= '0;
      acc_q <= '0;
      for (int i = 0; i < N_ENTRY; i++) begin
        b0_q[i] <= '0;
        ch_q[i] <= '0;
      end
    end else begin
      if (wr_sel) sel_q <= reg_wdata[IDX_W-1:0];
      if (wr_hi)  hi_q  <= reg_wdata;
      if (wr_lo) begin
        b1_q         <= reg_wdata[15:8];
        b0_q[sel_q]  <= reg_wdata[7:0];
        ch_q[sel_q]  <= reg_wdata[CH_LSB +: CHAN_W];
        acc_q[sel_q] <= reg_wdata[ACC_BIT];
        vld_q[sel_q] <= reg_wdata[VLD_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[IDX_W-1:0] = sel_q;
      2'd1: reg_rdata = hi_q;
      2'd2: reg_rdata[LO_W-1:0] = {vld_q[sel_q], acc_q[sel_q], ch_q[sel_q], b1_q, b0_q[sel_q]};
      default: reg_rdata = '0;
    endcase
  end

  wire pfx_ok = da[47:8] == {hi_q, b1_q};
  logic              any_m;
  logic [CHAN_W-1:0] win_ch;
  logic              win_acc;

  always_comb begin
    any_m   = 1'b0;
    win_ch  = '0;
    win_acc = 1'b0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (vld_q[i] && b0_q[i] == da[7:0]) begin
        any_m   = 1'b1;
        win_ch  = ch_q[i];
        win_acc = acc_q[i];
      end
    end
  end

  wire found = da_valid && pfx_ok && any_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit    <= 1'b0;
      chan   <= '0;
      accept <= 1'b0;
    end else begin
      hit    <= found;
      chan   <= found ? win_ch : '0;
      accept <= found && win_acc;
    end
  end
endmodule

// File: rtl/mac_match_table_chk.sv
module mac_match_table_chk #(
  parameter int N_ENTRY = 8,
  parameter int CHAN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              da_valid,
  input logic              hit,
  input logic [CHAN_W-1:0] chan,
  input logic              accept
);
  localparam int IDX_W = $clog2(N_ENTRY);
  localparam logic [31:0] LO_MASK = 32'((64'd1 << (CHAN_W + 18)) - 64'd1);
  localparam logic [31:0] SEL_MASK = 32'((64'd1 << IDX_W) - 64'd1);

  p_sel_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (reg_addr != 2'd0 || reg_rdata == ($past(reg_wdata) & SEL_MASK)));

  p_hi_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (reg_addr != 2'd1 || reg_rdata == $past(reg_wdata)));

  p_lo_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (reg_addr != 2'd2 || reg_rdata == ($past(reg_wdata) & LO_MASK)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> (!hit && chan == '0 && !accept));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (chan == '0 && !accept));

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r9: assert (!hit && chan == '0 && !accept);
endmodule

bind mac_match_table mac_match_table_chk #(.N_ENTRY(N_ENTRY), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .da_valid(da_valid), .hit(hit), .chan(chan), .accept(accept));

// File: tb/mac_match_table_test.sv
module mac_match_table_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        da_valid = 0;
  logic [47:0] da = 0;
  logic        hit, accept;
  logic [2:0]  chan;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mac_match_table uut (.*);

  localparam logic [47:0] PFX = 48'h000E_9902_FE00;
  // {address, hit, chan, accept}
  localparam logic [52:0] VEC [0:7] = '{
    {PFX | 48'h10,       1'b1, 3'd0, 1'b1},  // R5 plain hit, accept
    {PFX | 48'h11,       1'b1, 3'd5, 1'b0},  // R7 entries 1 and 3 both match, 1 wins; filter
    {PFX | 48'h12,       1'b0, 3'd0, 1'b0},  // R6 invalid entry
    {PFX | 48'h77,       1'b1, 3'd7, 1'b1},  // R5 highest index
    {PFX | 48'h55,       1'b0, 3'd0, 1'b0},  // R8 no byte 0 match
    {48'h000E_9902_FD10, 1'b0, 3'd0, 1'b0},  // R5 byte 1 differs
    {48'h010E_9902_FE10, 1'b0, 3'd0, 1'b0},  // R5 byte 5 differs
    {48'h000E_9903_FE11, 1'b0, 3'd0, 1'b0}   // R5 byte 2 differs
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic lookup(logic [47:0] a, output logic [4:0] res);
    @(negedge clk);
    da = a; da_valid = 1;
    @(negedge clk);
    res = {hit, chan, accept};
    da_valid = 0;
  endtask

  function automatic logic [31:0] lo(bit v, bit ac, logic [2:0] c, logic [7:0] b1, logic [7:0] b0);
    return {11'd0, v, ac, c, b1, b0};
  endfunction

  initial begin
    logic [31:0] d;
    logic [4:0]  r;
    repeat (3) @(negedge clk);
    check("R9 hit in reset", {29'd0, hit, chan, accept} , 0);
    rst_n = 1;
    rd(0, d); check("R9 selector after reset", d, 0);
    rd(1, d); check("R9 prefix after reset", d, 0);
    rd(2, d); check("R9 entry after reset", d, 0);
    lookup(48'h0, r); check("R9 invalid entries miss zero address", {27'd0, r}, 0);

    wr(0, 32'hFFFF_FFFD);
    rd(0, d); check("R1 selector readback", d, 32'd5);

    wr(0, 0);
    wr(1, 32'h000E_9902);
    rd(1, d); check("R2 prefix readback", d, 32'h000E_9902);
    wr(2, lo(1, 1, 0, 8'hFE, 8'h10));
    wr(0, 1); wr(2, lo(1, 0, 5, 8'hFE, 8'h11));
    wr(0, 2); wr(2, lo(0, 1, 3, 8'hFE, 8'h12));
    wr(0, 3); wr(2, lo(1, 1, 6, 8'hFE, 8'h11));
    for (int i = 4; i < 7; i++) begin
      wr(0, i); wr(2, lo(0, 0, 0, 8'hFE, 8'(8'h30 + i)));
    end
    wr(0, 7); wr(2, lo(1, 1, 7, 8'hFE, 8'h77));

    wr(0, 1); rd(2, d); check("R3 entry 1 readback", d, 32'h0015_FE11);
    wr(0, 2); rd(2, d); check("R3 entry 2 readback", d, 32'h000B_FE12);
    wr(0, 0); rd(2, d); check("R3 entry 0 untouched by later commits", d, 32'h0018_FE10);

    for (int i = 0; i < 8; i++) begin
      lookup(VEC[i][52:5], r);
      check($sformatf("R5/R6/R7/R8 vector %0d {hit,chan,acc}", i), {27'd0, r}, {27'd0, VEC[i][4:0]});
    end

    lookup(PFX | 48'h10, r);
    @(negedge clk);
    check("R8 outputs drop after strobe", {29'd0, hit, chan, accept}, 0);
    @(negedge clk); da = PFX | 48'h10; da_valid = 0;
    @(negedge clk);
    check("R8 no strobe no hit", {29'd0, hit, chan, accept}, 0);

    wr(0, 7); wr(2, lo(1, 1, 7, 8'hAB, 8'h77));
    wr(0, 0); rd(2, d); check("R4 shared byte 1 in entry 0 readback", d, 32'h0018_AB10);
    lookup(PFX | 48'h10, r); check("R4 old byte 1 misses", {27'd0, r}, 0);
    lookup(48'h000E_9902_AB10, r); check("R4 new byte 1 hits entry 0", {27'd0, r}, 5'b1_000_1);

    wr(2, lo(0, 1, 0, 8'hAB, 8'h10));
    lookup(48'h000E_9902_AB10, r); check("R6 entry 0 invalidated", {27'd0, r}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule